// File: doc/BRIEF.md
# RAM Browse and Edit Controller

This block lets an operator walk through a 256-location, byte-wide single-port memory and change any location with three button pulses: up, down and enter. The pulses are assumed to be debounced already and one clock cycle wide. The block keeps a current address. It shows that address on an 8-LED bus and sends one byte to a two-digit hexadecimal display driver.

A small state machine has three states. `ST_BROWSE` is the resting state. There, up and down step the address and the display shows the stored byte at that address. The transition `browse->edit` is taken on enter. It copies the stored byte into a working register. In `ST_EDIT`, up and down step the working byte instead of the address, and the display shows the working byte. The transition `edit->commit` is taken on enter. `ST_COMMIT` lasts exactly one cycle and drives the write strobe with the working byte. The transition `commit->browse` is then taken unconditionally.

The memory sits outside the block and has a combinational read port. Its read data is the byte at the address the block is driving in that same cycle. Writes are taken at the clock edge while the write strobe is high.

Top module: `ram_edit_ctrl`

## Requirements
- R1: While reset is low and after it is released, the address is 00, the state is browse, and the write strobe is low.
- R2: In browse, an up pulse raises the address by one and a down pulse lowers it by one, modulo 256: FF goes up to 00, and 00 goes down to FF.
- R3: An up and a down pulse in the same cycle cancel. Neither the address nor the working byte changes.
- R4: The LED bus always equals the memory address. In browse, the display byte equals the memory read data.
- R5: Enter in browse moves to edit and loads the working byte from the read data at that edge. The address does not change.
- R6: In edit, up and down raise or lower the working byte by one, modulo 256 (FF+1=00, 00-1=FF). The display shows the working byte.
- R7: Enter in edit produces exactly one cycle of write strobe, carrying the working byte to the current address, and then returns to browse. Any button pulse in that commit cycle is ignored.
- R8: When enter arrives in the same cycle as up or down, enter wins and the up or down pulse has no effect.
- R9: The write strobe is never high outside the commit cycle, and the address never changes in edit or commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_up | input | 1 | One-cycle up pulse |
| btn_down | input | 1 | One-cycle down pulse |
| btn_enter | input | 1 | One-cycle enter pulse |
| mem_addr | output | 8 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data (combinational) |
| led | output | 8 | Address shown in binary on LEDs |
| disp_byte | output | 8 | Byte sent to the hex display driver |

## Verification
The checker tests several rules on every clock edge. It checks the single-cycle write pulse and that the strobe is raised only from edit. It checks that the address holds steady in edit and commit, that browse steps the address, that edit steps the displayed byte, and that the edit load copies the read data. Other behaviour can only be shown by the bench's scenarios: whether the written value really lands at the right location and reappears on the display after return to browse, the wrap at 00 and FF for both address and data, and the enter-priority and cancel cases. The bench covers these with a reference memory and a reference model of the states, driven by directed corner cases and seeded random button traffic.

// File: rtl/ram_edit_pkg.sv
package ram_edit_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_BROWSE = 2'd0,
        ST_EDIT   = 2'd1,
        ST_COMMIT = 2'd2
    } ed_state_t;
endpackage

// File: rtl/ram_edit_step.sv
// Wrapping up/down register with priority load; used for address and working byte.
module ram_edit_step #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (inc && !dec) begin
            q <= q + ONE;
        end else if (dec && !inc) begin
            q <= q - ONE;
        end
    end
endmodule

// File: rtl/ram_edit_fsm.sv
module ram_edit_fsm
    import ram_edit_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      up,
    input  logic      down,
    input  logic      enter,
    output ed_state_t state,
    output logic      addr_inc,
    output logic      addr_dec,
    output logic      work_load,
    output logic      work_inc,
    output logic      work_dec,
    output logic      wr_en
);
    ed_state_t state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BROWSE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state: enter is the only transition trigger out of browse and edit
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BROWSE: if (enter) state_nx = ST_EDIT;
            ST_EDIT:   if (enter) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_BROWSE;
            default:   state_nx = ST_BROWSE;
        endcase
    end

    // Outputs: enter masks up/down; up and down together cancel
    always_comb begin
        addr_inc  = 1'b0;
        addr_dec  = 1'b0;
        work_load = 1'b0;
        work_inc  = 1'b0;
        work_dec  = 1'b0;
        wr_en     = 1'b0;
        unique case (state)
            ST_BROWSE: begin
                if (enter) begin
                    work_load = 1'b1;
                end else begin
                    addr_inc = up && !down;
                    addr_dec = down && !up;
                end
            end
            ST_EDIT: begin
                if (!enter) begin
                    work_inc = up && !down;
                    work_dec = down && !up;
                end
            end
            ST_COMMIT: begin
                wr_en = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ram_edit_ctrl.sv
module ram_edit_ctrl
    import ram_edit_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          btn_up,
    input  logic          btn_down,
    input  logic          btn_enter,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] led,
    output logic [DW-1:0] disp_byte
);
    ed_state_t     state_q;
    logic          addr_inc, addr_dec;
    logic          work_load, work_inc, work_dec;
    logic          wr_en;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] work_q;

    ram_edit_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .up        (btn_up),
        .down      (btn_down),
        .enter     (btn_enter),
        .state     (state_q),
        .addr_inc  (addr_inc),
        .addr_dec  (addr_dec),
        .work_load (work_load),
        .work_inc  (work_inc),
        .work_dec  (work_dec),
        .wr_en     (wr_en)
    );

    ram_edit_step #(.W(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (1'b0),
        .load_val ({AW{1'b0}}),
        .inc      (addr_inc),
        .dec      (addr_dec),
        .q        (addr_q)
    );

    ram_edit_step #(.W(DW)) u_work (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (work_load),
        .load_val (mem_rdata),
        .inc      (work_inc),
        .dec      (work_dec),
        .q        (work_q)
    );

    assign mem_addr  = addr_q;
    assign led       = addr_q;
    assign mem_we    = wr_en;
    assign mem_wdata = work_q;
    assign disp_byte = (state_q == ST_BROWSE) ? mem_rdata : work_q;
endmodule

// File: rtl/ram_edit_ctrl_chk.sv
module ram_edit_ctrl_chk
    import ram_edit_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          btn_up,
    input logic          btn_down,
    input logic          btn_enter,
    input ed_state_t     state,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic [DW-1:0] mem_rdata,
    input logic [DW-1:0] disp_byte
);
    localparam logic [AW-1:0] A1 = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] D1 = {{(DW-1){1'b0}}, 1'b1};

    // R7
    we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R9
    we_from_edit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(state) == ST_EDIT);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_BROWSE) |=> $stable(mem_addr));

    // R2
    addr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BROWSE && btn_up && !btn_down && !btn_enter)
        |=> mem_addr == $past(mem_addr) + A1);

    // R2
    addr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BROWSE && btn_down && !btn_up && !btn_enter)
        |=> mem_addr == $past(mem_addr) - A1);

    // R5
    edit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BROWSE && btn_enter) |=> disp_byte == $past(mem_rdata));

    // R6
    work_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EDIT && btn_up && !btn_down && !btn_enter)
        |=> disp_byte == $past(disp_byte) + D1);
endmodule

bind ram_edit_ctrl ram_edit_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .btn_up    (btn_up),
    .btn_down  (btn_down),
    .btn_enter (btn_enter),
    .state     (state_q),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .disp_byte (disp_byte)
);

// File: tb/ram_edit_ctrl_test.sv
module ram_edit_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_up = 1'b0, btn_down = 1'b0, btn_enter = 1'b0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, led, disp_byte;
    logic       mem_we;

    logic [7:0] ram     [256];
    logic [7:0] ref_mem [256];

    int n_chk = 0;
    int n_fail = 0;
    int m_state = 0;        // 0 browse, 1 edit, 2 commit
    logic [7:0] m_addr = 8'h00;
    logic [7:0] m_work = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    ram_edit_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .btn_up(btn_up), .btn_down(btn_down), .btn_enter(btn_enter),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .led(led), .disp_byte(disp_byte)
    );

    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

    function automatic logic [7:0] init_val(input int i);
        return ~i[7:0];
    endfunction

    function automatic logic [7:0] step8(input logic [7:0] v, input logic u, input logic d);
        if (u && !d) return v + 8'd1;
        if (d && !u) return v - 8'd1;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R4 led"}, led, m_addr);
        chk({tag, " R9 addr"}, mem_addr, m_addr);
        chk({tag, " R7 we"}, {7'd0, mem_we}, {7'd0, m_state == 2});
        if (m_state == 0) chk({tag, " R4 disp"}, disp_byte, ref_mem[m_addr]);
        else              chk({tag, " R6 disp"}, disp_byte, m_work);
        if (m_state == 2) chk({tag, " R7 wdata"}, mem_wdata, m_work);
    endtask

    // One cycle of buttons, model update at the edge, then check
    task automatic press(input string tag, input logic u, input logic d, input logic e);
        @(negedge clk);
        btn_up = u; btn_down = d; btn_enter = e;
        @(posedge clk);
        case (m_state)
            0: if (e) begin m_work = ref_mem[m_addr]; m_state = 1; end
               else m_addr = step8(m_addr, u, d);
            1: if (e) m_state = 2;
               else m_work = step8(m_work, u, d);
            default: begin ref_mem[m_addr] = m_work; m_state = 0; end
        endcase
        #1;
        btn_up = 1'b0; btn_down = 1'b0; btn_enter = 1'b0;
        #2;
        check_all(tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog timeout");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        for (int i = 0; i < 256; i++) begin
            ram[i] = init_val(i);
            ref_mem[i] = init_val(i);
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 led in reset", led, 8'h00);
        chk("R1 we in reset", {7'd0, mem_we}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 led after reset", led, 8'h00);
        chk("R1 browse disp", disp_byte, init_val(0));
        check_all("R1");

        // R2: wrap downward and upward
        press("R2 down wrap", 1'b0, 1'b1, 1'b0);
        chk("R2 00-1", led, 8'hFF);
        press("R2 up wrap", 1'b1, 1'b0, 1'b0);
        chk("R2 FF+1", led, 8'h00);

        // R3: simultaneous up and down in browse
        press("R3 cancel browse", 1'b1, 1'b1, 1'b0);
        chk("R3 addr held", led, 8'h00);

        // R8: enter with up in browse -> edit, address unchanged
        press("R8 enter+up", 1'b1, 1'b0, 1'b1);
        chk("R8 addr held", led, 8'h00);
        chk("R5 load", disp_byte, 8'hFF);

        // R6: data wrap FF+1 -> 00, then 00-1 -> FF, then cancel
        press("R6 data up", 1'b1, 1'b0, 1'b0);
        chk("R6 FF+1", disp_byte, 8'h00);
        press("R6 data down", 1'b0, 1'b1, 1'b0);
        chk("R6 00-1", disp_byte, 8'hFF);
        press("R3 cancel edit", 1'b1, 1'b1, 1'b0);
        chk("R3 data held", disp_byte, 8'hFF);
        press("R6 data down2", 1'b0, 1'b1, 1'b0);
        chk("R9 addr in edit", led, 8'h00);

        // R7: commit with down pressed alongside (R8), then ignored button in commit
        press("R7 enter+down", 1'b0, 1'b1, 1'b1);
        chk("R7 strobe", {7'd0, mem_we}, 8'h01);
        chk("R7 wdata", mem_wdata, 8'hFE);
        press("R7 ignore in commit", 1'b1, 1'b0, 1'b0);
        chk("R7 strobe gone", {7'd0, mem_we}, 8'h00);
        chk("R7 addr after commit", led, 8'h00);
        chk("R7 stored", disp_byte, 8'hFE);

        // Random traffic
        for (int n = 0; n < 6000; n++) begin
            logic u, d, e;
            u = ($urandom % 4) == 0;
            d = ($urandom % 4) == 0;
            e = ($urandom % 6) == 0;
            press("random", u, d, e);
        end

        // Final memory comparison
        for (int i = 0; i < 256; i++) chk("R7 memory contents", ram[i], ref_mem[i]);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule